// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider

This block divides one unsigned W-bit operand by another over several clock cycles. It returns a quotient and a remainder that satisfy dividend = divisor × quotient + remainder, with the remainder below the divisor. A one-cycle start strobe captures both operands. A restoring shift-and-subtract loop then produces one quotient bit per cycle.

Before the loop begins, the dividend is normalised so that its highest set bit sits at the top of the word. The loop therefore runs only for the dividend's significant bits, not for all W of them, and the latency depends on the magnitude of the dividend. When the result is ready, the block raises a one-cycle completion strobe. It also reports how many cycles elapsed between the start cycle and the strobe cycle. The quotient, remainder and cycle count then stay unchanged until the next operation completes.

Top module: `seq_divider`

## Requirements
- R1: For any divisor other than zero, each completed operation yields quotient and remainder with dividend = divisor × quotient + remainder and remainder < divisor, all unsigned.
- R2: Each accepted start produces exactly one cycle with `done_o` high; `done_o` is low in every other cycle.
- R3: `cycles_o` equals the index of the cycle in which `done_o` is high minus the index of the cycle in which `start_i` was high. For a nonzero dividend and nonzero divisor, this value is 1 plus the dividend's significant bit count (the position of its highest set bit, counted from 1 at bit 0).
- R4: A zero divisor completes with the quotient all ones, the remainder equal to the dividend, and `cycles_o` = 1.
- R5: A zero dividend with a nonzero divisor completes with quotient 0, remainder 0 and `cycles_o` = 1.
- R6: `quot_o`, `rem_o` and `cycles_o` keep their values from one completion to the next, whatever the operand inputs do in between.
- R7: A start strobe that arrives while an operation is in progress is ignored. The running operation finishes with its own result and timing.
- R8: While reset is held, and just after it is released, `done_o`, `quot_o`, `rem_o` and `cycles_o` are all 0.
- R9: The operands are sampled only in the start cycle. Changes on `dividend_i` or `divisor_i` during the operation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a division |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| quot_o | output | W | Quotient of the last completed operation |
| rem_o | output | W | Remainder of the last completed operation |
| done_o | output | 1 | One-cycle completion strobe |
| cycles_o | output | CW | Cycles from the start cycle to the completion cycle |

## Verification
The bench targets the following corner cases:

- **All-ones dividend over a divisor of one.** This runs the longest loop. A design that miscounts the significant bits would report the wrong latency, and one that mis-normalises would lose quotient bits.
- **Divisor larger than the dividend, and divisor equal to the dividend.** These check the subtract-or-keep decision at its boundary. An off-by-one in the borrow test gives a remainder equal to the divisor, or a quotient of zero instead of one.
- **Zero divisor and zero dividend.** These must finish after one cycle with fixed results. A design that enters the loop on these inputs would hang or return garbage.
- **Late events during a run.** The bench changes the operands mid-run and pulses start during a run. A design that re-samples the operands, or restarts on the second strobe, would return the wrong quotient or a longer cycle count.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_LOOP = 1'b1
    } div_phase_e;

    // width able to hold a bit count of 0..w
    function automatic int bits_width(input int w);
        return $clog2(w + 1);
    endfunction

    // width able to hold the worst latency w+1
    function automatic int cycles_width(input int w);
        return $clog2(w + 2);
    endfunction

endpackage

// File: rtl/div_norm.sv
module div_norm #(
    parameter int W  = 32,
    parameter int BW = div_pkg::bits_width(W)
) (
    input  logic [W-1:0]  value_i,
    output logic [W-1:0]  aligned_o,
    output logic [BW-1:0] sig_bits_o
);
    // one-hot marker of the highest set bit
    logic [W-1:0] top_hit;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_hit
            if (gi == W - 1) begin : g_msb
                assign top_hit[gi] = value_i[gi];
            end else begin : g_low
                assign top_hit[gi] = value_i[gi] & ~(|value_i[W-1:gi+1]);
            end
        end
    endgenerate

    logic [BW-1:0] shamt;

    always_comb begin
        sig_bits_o = '0;
        for (int i = 0; i < W; i++) begin
            if (top_hit[i]) sig_bits_o = BW'(i + 1);
        end
        shamt     = BW'(W) - sig_bits_o;
        aligned_o = value_i << shamt;
    end

endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] shreg_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] part_o,
    output logic [W-1:0] shreg_o
);
    typedef struct packed {
        logic [W-1:0] part;
        logic [W-1:0] shreg;
    } step_t;

    logic [W:0]   window;
    logic [W+1:0] diff;
    logic         fits;
    step_t        nxt;

    always_comb begin
        window    = {part_i, shreg_i[W-1]};
        diff      = {1'b0, window} - {2'b00, divisor_i};
        fits      = ~diff[W+1];
        nxt.part  = fits ? diff[W-1:0] : window[W-1:0];
        nxt.shreg = {shreg_i[W-2:0], fits};
        part_o    = nxt.part;
        shreg_o   = nxt.shreg;
    end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int W  = 32,
    parameter int BW = bits_width(W),
    parameter int CW = cycles_width(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [BW-1:0] sig_bits_i,
    input  logic          zero_div_i,
    output logic          accept_o,
    output logic          quick_o,
    output logic          last_o,
    output logic          busy_o,
    output logic [CW-1:0] elapsed_o
);
    div_phase_e    phase;
    logic [BW-1:0] left;
    logic [CW-1:0] elapsed;

    assign busy_o    = (phase == PH_LOOP);
    assign accept_o  = (phase == PH_IDLE) && start_i;
    assign quick_o   = accept_o && (zero_div_i || (sig_bits_i == '0));
    assign last_o    = busy_o && (left == BW'(1));
    assign elapsed_o = elapsed;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            left    <= '0;
            elapsed <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept_o && !quick_o) begin
                        phase   <= PH_LOOP;
                        left    <= sig_bits_i;
                        elapsed <= CW'(1);
                    end
                end
                PH_LOOP: begin
                    left    <= left - BW'(1);
                    elapsed <= elapsed + CW'(1);
                    if (left == BW'(1)) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int W = 32,
    localparam int BW = bits_width(W),
    localparam int CW = cycles_width(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [W-1:0]  dividend_i,
    input  logic [W-1:0]  divisor_i,
    output logic [W-1:0]  quot_o,
    output logic [W-1:0]  rem_o,
    output logic          done_o,
    output logic [CW-1:0] cycles_o
);
    logic [W-1:0]  aligned;
    logic [BW-1:0] sig_bits;
    logic          accept, quick, last, busy;
    logic [CW-1:0] elapsed;

    logic [W-1:0]  part_q, shreg_q, dvs_q;
    logic [W-1:0]  part_nx, shreg_nx;

    div_norm #(.W(W), .BW(BW)) u_norm (
        .value_i    (dividend_i),
        .aligned_o  (aligned),
        .sig_bits_o (sig_bits)
    );

    div_ctrl #(.W(W), .BW(BW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .sig_bits_i (sig_bits),
        .zero_div_i (divisor_i == '0),
        .accept_o   (accept),
        .quick_o    (quick),
        .last_o     (last),
        .busy_o     (busy),
        .elapsed_o  (elapsed)
    );

    div_step #(.W(W)) u_step (
        .part_i    (part_q),
        .shreg_i   (shreg_q),
        .divisor_i (dvs_q),
        .part_o    (part_nx),
        .shreg_o   (shreg_nx)
    );

    // iteration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            part_q  <= '0;
            shreg_q <= '0;
            dvs_q   <= '0;
        end else if (accept) begin
            part_q  <= '0;
            shreg_q <= aligned;
            dvs_q   <= divisor_i;
        end else if (busy) begin
            part_q  <= part_nx;
            shreg_q <= shreg_nx;
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            quot_o   <= '0;
            rem_o    <= '0;
            cycles_o <= '0;
            done_o   <= 1'b0;
        end else if (quick) begin
            quot_o   <= (divisor_i == '0) ? '1 : '0;
            rem_o    <= dividend_i;
            cycles_o <= CW'(1);
            done_o   <= 1'b1;
        end else if (last) begin
            quot_o   <= shreg_nx;
            rem_o    <= part_nx;
            cycles_o <= elapsed + CW'(1);
            done_o   <= 1'b1;
        end else begin
            done_o   <= 1'b0;
        end
    end

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          busy,
    input logic          done_o,
    input logic [W-1:0]  quot_o,
    input logic [W-1:0]  rem_o,
    input logic [W-1:0]  dvs_q,
    input logic [CW-1:0] cycles_o
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst)                  pend <= 1'b0;
        else if (start_i && !busy) pend <= 1'b1;
        else if (done_o)          pend <= 1'b0;
    end

    assert_single_done_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_has_request_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> pend);

    assert_rem_below_div_R1: assert property (@(posedge clk) disable iff (rst)
        (done_o && dvs_q != '0) |-> (rem_o < dvs_q));

    assert_zero_div_ones_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && dvs_q == '0) |-> (quot_o == '1));

    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cycles_o >= CW'(1) && cycles_o <= CW'(W + 1)));

    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(cycles_o)));

endmodule

bind seq_divider div_checker #(.W(W), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy     (busy),
    .done_o   (done_o),
    .quot_o   (quot_o),
    .rem_o    (rem_o),
    .dvs_q    (dvs_q),
    .cycles_o (cycles_o)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
    localparam int  W    = 20;
    localparam int  CW   = $clog2(W + 2);
    localparam time TCLK = 10ns;
    localparam int  NV   = 11;

    localparam logic [W-1:0] VEC_N [NV] = '{
        20'd18, 20'd18, 20'd1350, 20'd202103, 20'hFFFFF, 20'hFFFFF,
        20'd3, 20'd7, 20'd524288, 20'd1, 20'd999999 };
    localparam logic [W-1:0] VEC_D [NV] = '{
        20'd3, 20'd7, 20'd5, 20'd9, 20'd1, 20'hFFFFF,
        20'd7, 20'd7, 20'd3, 20'd1, 20'd1000 };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [W-1:0]  dividend_i = '0;
    logic [W-1:0]  divisor_i = '0;
    logic [W-1:0]  quot_o, rem_o;
    logic          done_o;
    logic [CW-1:0] cycles_o;

    int total = 0;
    int fails = 0;

    always #(TCLK / 2) clk = ~clk;

    seq_divider #(.W(W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .quot_o     (quot_o),
        .rem_o      (rem_o),
        .done_o     (done_o),
        .cycles_o   (cycles_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cycles(input logic [W-1:0] n, input logic [W-1:0] d);
        int nb = 0;
        for (int i = 0; i < W; i++) if (n[i]) nb = i + 1;
        if (n == '0 || d == '0) return 1;
        return nb + 1;
    endfunction

    // launch one division; optionally disturb operands and start mid-run
    task automatic run_div(input logic [W-1:0] n, input logic [W-1:0] d, input bit disturb);
        int  waited;
        bit  seen;
        logic [W-1:0] eq, er;
        logic [W-1:0] q0, r0;
        logic [CW-1:0] c0;
        if (d == '0) begin eq = '1; er = n; end
        else begin eq = n / d; er = n % d; end
        @(negedge clk);
        dividend_i = n; divisor_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited  = 1;
        seen    = 1'b0;
        if (disturb) begin dividend_i = ~n; divisor_i = d + 1; end
        while (!seen && waited < W + 6) begin
            if (done_o) begin
                seen = 1'b1;
            end else begin
                if (disturb && waited == 2) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                waited++;
            end
        end
        chk("R2 done seen", seen, 1);
        chk("R3 strobe distance", waited, exp_cycles(n, d));
        chk("R3 cycles_o", cycles_o, exp_cycles(n, d));
        chk(disturb ? "R9 quotient" : "R1 quotient", quot_o, eq);
        chk(disturb ? "R7 remainder" : "R1 remainder", rem_o, er);
        q0 = quot_o; r0 = rem_o; c0 = cycles_o;
        @(negedge clk);
        chk("R2 done drops", done_o, 0);
        dividend_i = ~dividend_i; divisor_i = divisor_i ^ 20'h5A5A5;
        repeat (3) @(negedge clk);
        chk("R6 quotient held", quot_o, q0);
        chk("R6 remainder held", rem_o, r0);
        chk("R6 count held", cycles_o, c0);
        chk("R2 done stays low", done_o, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(TCLK * 100000);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 done in reset", done_o, 0);
        chk("R8 quotient in reset", quot_o, 0);
        chk("R8 remainder in reset", rem_o, 0);
        chk("R8 count in reset", cycles_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 done after reset", done_o, 0);

        for (int v = 0; v < NV; v++) run_div(VEC_N[v], VEC_D[v], 1'b0);

        // R4 zero divisor
        run_div(20'd12345, 20'd0, 1'b0);
        // R5 zero dividend
        run_div(20'd0, 20'd77, 1'b0);
        // R7 and R9: mid-run start and operand change
        run_div(20'd987654, 20'd13, 1'b1);
        run_div(20'hFFFFF, 20'd2, 1'b1);

        summary();
        $finish;
    end

endmodule